// File: doc/BRIEF.md
# Byte-to-word ATA data packer

This block sits between an 8-bit host I/O port and the 16-bit data bus of an ATA/IDE device. Normally the host moves a sector through the data register one byte at a time. The block pairs those byte accesses, so that two host bytes make one 16-bit device access. On a write, the first host byte is held and the second host write fires the device write strobe with the whole word. On a read, the first host read fires the device read strobe, returns the low byte and keeps the high byte. The second host read returns the kept byte and does not strobe the device.

A read/write-long mode lets the ECC bytes that trail a sector cross the bus one byte per device strobe. While the mode enable is set, the block counts bytes through the data register. Once a full sector of bytes has passed, every host data access produces its own device strobe on the low byte lanes. Any host write to a task-file register other than the data register clears the count and the pairing phase, so pairing starts again. The device strobes are combinational from the host strobe in the same cycle. Host read data is registered and appears one cycle after the host read strobe.

Top module: `ata_byte_packer`

## Requirements
- R1: After reset no device strobe is active, the host read data is 8'h00, and the first data-register write is treated as the low byte of a pair.
- R2: In pairing mode, the first host write to offset 0 produces no device strobe and holds the byte. The second host write asserts dev_wr_o in the same cycle, with dev_data_o = {second byte, first byte}.
- R3: In pairing mode, the first host read of offset 0 asserts dev_rd_o in the same cycle and returns dev_data_i[7:0] one cycle later. The second host read returns the saved dev_data_i[15:8] without asserting dev_rd_o.
- R4: While long_en_i is 0, pairing continues no matter how many bytes pass, including well beyond 512.
- R5: While long_en_i is 1, once 512 data-register accesses have been counted, every later host write to offset 0 asserts dev_wr_o in the same cycle with dev_data_o = {8'h00, byte}. The byte count never goes past 512.
- R6: In the byte-per-strobe phase, every host read of offset 0 asserts dev_rd_o and returns dev_data_i[7:0] one cycle later.
- R7: A host write to any offset from 1 to 7 clears the byte count and the pairing phase. It produces no device strobe, and the next data-register write becomes the low byte of a new pair.
- R8: A host read of an offset from 1 to 7 produces no device strobe, does not advance the pairing phase or the count, and returns 8'h00.
- R9: Clearing long_en_i while in the byte-per-strobe phase brings pairing back at once.
- R10: dev_rd_o and dev_wr_o are never high together, and host_rdata_o changes only in the cycle after a host read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| long_en_i | input | 1 | Read/write-long mode enable, cleared by its owner at reset |
| host_addr_i | input | 3 | Task-file register offset, 0 = data register |
| host_wdata_i | input | 8 | Host write byte |
| host_wr_i | input | 1 | Host write strobe, one cycle per access |
| host_rd_i | input | 1 | Host read strobe, one cycle per access, ignored when host_wr_i is high |
| host_rdata_o | output | 8 | Host read byte, valid the cycle after host_rd_i |
| dev_data_i | input | 16 | Device read data, sampled while dev_rd_o is high |
| dev_data_o | output | 16 | Device write data, valid while dev_wr_o is high |
| dev_wr_o | output | 1 | Device write strobe |
| dev_rd_o | output | 1 | Device read strobe |

## Verification
A wrong pairing phase shows at the very next data access: the device strobe fires on the wrong host byte, or the write word has its two bytes swapped. A wrong byte count shows only at the sector boundary, where single-byte strobes start one access early or late. For that reason the bench pushes exactly 512 bytes and then watches the next few accesses one at a time. A stale high-byte buffer or a bad re-arm shows within one pair, as a wrong returned byte or a missing strobe.

// File: rtl/ata_pack_pkg.sv
package ata_pack_pkg;
  localparam int unsigned ADDR_W       = 3;
  localparam int unsigned BYTE_W       = 8;
  localparam int unsigned WORD_W       = 2 * BYTE_W;
  localparam int unsigned SECTOR_BYTES = 512;
  localparam logic [ADDR_W-1:0] DATA_OFS = '0;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_WR    = 2'd1,
    ACC_RD    = 2'd2
  } acc_e;
endpackage

// File: rtl/pack_ctrl.sv
module pack_ctrl #(
  parameter int unsigned SECTOR_BYTES = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic long_en_i,
  input  logic data_acc_i,
  input  logic rearm_i,
  output logic byte_mode_o,
  output logic hi_phase_o
);
  localparam int unsigned CNT_W = $clog2(SECTOR_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SECTOR_BYTES);

  logic [CNT_W-1:0] cnt_q;
  logic             hi_q;
  logic             full;

  assign full        = (cnt_q == CNT_FULL);
  assign byte_mode_o = long_en_i && full;
  assign hi_phase_o  = hi_q;

  // Count bytes only while the long mode is armed; saturate at one sector.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cnt_q <= '0;
    else if (rearm_i)                         cnt_q <= '0;
    else if (data_acc_i && long_en_i && !full) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            hi_q <= 1'b0;
    else if (rearm_i)                       hi_q <= 1'b0;
    else if (data_acc_i && !byte_mode_o)    hi_q <= ~hi_q;
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL);

  // R5
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_acc_i && long_en_i && !rearm_i && !full) |=> (cnt_q - $past(cnt_q)) == CNT_W'(1));

  // R7
  rearm_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_i |=> (cnt_q == '0) && !hi_q);

  // R9
  long_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !long_en_i |-> !byte_mode_o);
endmodule

// File: rtl/pack_datapath.sv
module pack_datapath #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned WORD_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_data_i,
  input  logic              rd_data_i,
  input  logic              rd_other_i,
  input  logic              byte_mode_i,
  input  logic              hi_phase_i,
  input  logic [BYTE_W-1:0] host_wdata_i,
  input  logic [WORD_W-1:0] dev_data_i,
  output logic [BYTE_W-1:0] host_rdata_o,
  output logic [WORD_W-1:0] dev_data_o,
  output logic              dev_wr_o,
  output logic              dev_rd_o
);
  logic [BYTE_W-1:0] lo_q;
  logic [BYTE_W-1:0] hi_q;
  logic [BYTE_W-1:0] rdata_q;

  assign dev_wr_o   = wr_data_i && (byte_mode_i || hi_phase_i);
  assign dev_rd_o   = rd_data_i && (byte_mode_i || !hi_phase_i);
  assign dev_data_o = byte_mode_i ? {{BYTE_W{1'b0}}, host_wdata_i}
                                  : {host_wdata_i, lo_q};
  assign host_rdata_o = rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (wr_data_i && !byte_mode_i && !hi_phase_i) lo_q <= host_wdata_i;
      if (rd_data_i && !byte_mode_i && !hi_phase_i) hi_q <= dev_data_i[WORD_W-1:BYTE_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_q <= '0;
    else if (rd_data_i) rdata_q <= dev_rd_o ? dev_data_i[BYTE_W-1:0] : hi_q;
    else if (rd_other_i) rdata_q <= '0;
  end

  // R10
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dev_rd_o && dev_wr_o));

  // R10
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_data_i || rd_other_i) |=> $stable(host_rdata_o));

  // R6
  byte_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_rd_o && byte_mode_i) |=> host_rdata_o == $past(dev_data_i[BYTE_W-1:0]));
endmodule

// File: rtl/ata_byte_packer.sv
module ata_byte_packer
  import ata_pack_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              long_en_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [BYTE_W-1:0] host_wdata_i,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  output logic [BYTE_W-1:0] host_rdata_o,
  input  logic [WORD_W-1:0] dev_data_i,
  output logic [WORD_W-1:0] dev_data_o,
  output logic              dev_wr_o,
  output logic              dev_rd_o
);
  acc_e acc;
  logic is_data, wr_data, rd_data, rd_other, rearm;
  logic byte_mode, hi_phase;

  // Write wins when both host strobes are high.
  always_comb begin
    if (host_wr_i)      acc = ACC_WR;
    else if (host_rd_i) acc = ACC_RD;
    else                acc = ACC_NONE;
  end

  assign is_data  = (host_addr_i == DATA_OFS);
  assign wr_data  = (acc == ACC_WR) && is_data;
  assign rd_data  = (acc == ACC_RD) && is_data;
  assign rd_other = (acc == ACC_RD) && !is_data;
  assign rearm    = (acc == ACC_WR) && !is_data;

  pack_ctrl #(.SECTOR_BYTES(SECTOR_BYTES)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .long_en_i   (long_en_i),
    .data_acc_i  (wr_data || rd_data),
    .rearm_i     (rearm),
    .byte_mode_o (byte_mode),
    .hi_phase_o  (hi_phase)
  );

  pack_datapath #(.BYTE_W(BYTE_W)) u_dp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_data_i    (wr_data),
    .rd_data_i    (rd_data),
    .rd_other_i   (rd_other),
    .byte_mode_i  (byte_mode),
    .hi_phase_i   (hi_phase),
    .host_wdata_i (host_wdata_i),
    .dev_data_i   (dev_data_i),
    .host_rdata_o (host_rdata_o),
    .dev_data_o   (dev_data_o),
    .dev_wr_o     (dev_wr_o),
    .dev_rd_o     (dev_rd_o)
  );

  // R2
  pair_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_wr_o && !byte_mode) |=> !hi_phase);

  // R8
  other_rd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_other |-> !dev_rd_o && !dev_wr_o);

  // R7
  rearm_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm |-> !dev_wr_o && !dev_rd_o);
endmodule

// File: tb/ata_byte_packer_test.sv
module ata_byte_packer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        long_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [7:0]  rdata;
  logic [15:0] dev_in = '0;
  logic [15:0] dev_out;
  logic        dev_wr, dev_rd;

  int checks = 0;
  int fails  = 0;

  bit          q_wr[$];
  logic [15:0] q_dat[$];
  string       q_req[$];

  // bench model of the requirements
  bit         m_hi = 0;
  int         m_cnt = 0;
  logic [7:0] m_lo = '0;
  logic [7:0] m_hiq = '0;

  always #2.5 clk = ~clk;

  ata_byte_packer uut (
    .clk_i(clk), .rst_ni(rst_n), .long_en_i(long_en),
    .host_addr_i(addr), .host_wdata_i(wdata), .host_wr_i(wr), .host_rd_i(rd),
    .host_rdata_o(rdata), .dev_data_i(dev_in), .dev_data_o(dev_out),
    .dev_wr_o(dev_wr), .dev_rd_o(dev_rd)
  );

  function automatic bit m_byte_mode();
    return long_en && (m_cnt == 512);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push(input bit is_wr, input logic [15:0] d, input string req);
    q_wr.push_back(is_wr); q_dat.push_back(d); q_req.push_back(req);
  endtask

  // monitor: every device strobe must match the next expected item
  initial begin
    forever begin
      @(negedge clk); #1;
      if (dev_wr || dev_rd) begin
        if (q_wr.size() == 0) begin
          check(1'b0, "R10", "unexpected device strobe", {14'd0, dev_wr, dev_rd}, 16'd0);
        end else begin
          bit e_wr; logic [15:0] e_d; string e_r;
          e_wr = q_wr.pop_front(); e_d = q_dat.pop_front(); e_r = q_req.pop_front();
          check(dev_wr == e_wr && dev_rd == !e_wr, e_r, "strobe kind",
                {14'd0, dev_wr, dev_rd}, {14'd0, e_wr, !e_wr});
          if (e_wr) check(dev_out == e_d, e_r, "device write word", dev_out, e_d);
        end
      end
    end
  end

  task automatic host_write(input logic [2:0] a, input logic [7:0] d, input string req);
    if (a != 3'd0) begin
      m_cnt = 0; m_hi = 0;
    end else begin
      if (m_byte_mode()) push(1'b1, {8'h00, d}, req);
      else if (m_hi) push(1'b1, {d, m_lo}, req);
      else m_lo = d;
      if (!m_byte_mode()) m_hi = !m_hi;
      if (long_en && m_cnt < 512) m_cnt++;
    end
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic host_read(input logic [2:0] a, input logic [15:0] dev_word, input string req);
    logic [7:0] exp;
    if (a != 3'd0) exp = 8'h00;
    else begin
      if (m_byte_mode()) begin
        push(1'b0, dev_word, req); exp = dev_word[7:0];
      end else if (!m_hi) begin
        push(1'b0, dev_word, req); exp = dev_word[7:0]; m_hiq = dev_word[15:8];
      end else exp = m_hiq;
      if (!m_byte_mode()) m_hi = !m_hi;
      if (long_en && m_cnt < 512) m_cnt++;
    end
    @(negedge clk);
    addr = a; dev_in = dev_word; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    #2;
    check(rdata == exp, req, "host read byte", {8'h00, rdata}, {8'h00, exp});
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 16'd0, 16'd1);
    summary();
  end

  initial begin
    #1;
    // R1: reset state
    check(rdata == 8'h00 && !dev_wr && !dev_rd, "R1", "reset outputs",
          {rdata, 6'd0, dev_wr, dev_rd}, 16'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(rdata == 8'h00 && !dev_wr && !dev_rd, "R1", "after reset release",
          {rdata, 6'd0, dev_wr, dev_rd}, 16'd0);

    // R2: pairing writes
    host_write(3'd0, 8'h11, "R2"); host_write(3'd0, 8'h22, "R2");
    host_write(3'd0, 8'hA5, "R2"); host_write(3'd0, 8'h5A, "R2");
    host_write(3'd0, 8'hFF, "R2"); host_write(3'd0, 8'h00, "R2");

    // R3: pairing reads
    host_read(3'd0, 16'hBEEF, "R3"); host_read(3'd0, 16'h1234, "R3");
    host_read(3'd0, 16'h8001, "R3"); host_read(3'd0, 16'h0000, "R3");

    // R10: read data holds through idle cycles
    repeat (4) @(negedge clk);
    check(rdata == 8'h80, "R10", "read data held", {8'h00, rdata}, 16'h0080);

    // R8: other-register reads do not disturb the pair
    host_write(3'd0, 8'h31, "R8");
    host_read(3'd4, 16'hCAFE, "R8");
    host_write(3'd0, 8'h32, "R8");

    // R4: long mode off, far past one sector
    for (int i = 0; i < 600; i++) host_write(3'd0, 8'(i), "R4");

    // R7: re-arm with an odd byte pending
    host_write(3'd0, 8'h77, "R7");
    host_write(3'd3, 8'h01, "R7");
    host_write(3'd0, 8'h41, "R7"); host_write(3'd0, 8'h42, "R7");

    // R5: long mode, one sector then single-byte strobes
    long_en = 1'b1;
    for (int i = 0; i < 512; i++) host_write(3'd0, 8'(i * 3), "R5");
    host_write(3'd0, 8'hE1, "R5"); host_write(3'd0, 8'hE2, "R5");
    host_write(3'd0, 8'hE3, "R5");

    // R6: byte-phase reads
    host_read(3'd0, 16'h99C3, "R6"); host_read(3'd0, 16'h663C, "R6");
    host_read(3'd0, 16'h0180, "R6");

    // R8: other-register read in byte phase
    host_read(3'd6, 16'hFFFF, "R8");
    host_write(3'd0, 8'hE4, "R8");

    // R7: re-arm ends the byte phase
    host_write(3'd1, 8'h00, "R7");
    host_write(3'd0, 8'hC1, "R7"); host_write(3'd0, 8'hC2, "R7");

    // R9: reach the byte phase again, then drop the enable
    for (int i = 0; i < 510; i++) host_read(3'd0, 16'(i * 7), "R9");
    host_write(3'd0, 8'hD0, "R9");
    long_en = 1'b0;
    host_write(3'd0, 8'hD1, "R9"); host_write(3'd0, 8'hD2, "R9");
    host_read(3'd0, 16'h4321, "R9"); host_read(3'd0, 16'h8765, "R9");

    repeat (4) @(negedge clk);
    check(q_wr.size() == 0, "R10", "pending expected strobes",
          16'(q_wr.size()), 16'd0);
    summary();
  end
endmodule